// File: doc/BRIEF.md
# DRAM Rank Boundary Address Decoder

This block turns a physical address into the DRAM rank and channel that hold it. Software loads, through a small byte-wide register port, four cumulative rank boundaries per channel for two channels and a 3-bit page-size attribute for every rank. From these values the block decides by itself how the channels are organised. When both channels are populated identically, every rank is spread across both channels, and address bit 7 picks the channel. Otherwise the channels are asymmetric: channel 1's ranks sit in the address space directly above the top of channel 0.

Each lookup takes one address in and gives back one result: a hit flag, the rank index, the channel, the rank's attribute code, and an error flag for reserved attribute codes. The lookup interface is valid/ready on both sides, with one register stage between them. An address is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the result register is empty or its contents leave in the same cycle, so back-pressure on `out_ready` stalls the input without a bubble. Once `out_valid` is asserted, the result and `out_valid` hold steady until `out_ready` takes them. The configuration port is a plain write strobe with no handshake.

Top module: `rank_addr_decoder`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and all boundary and attribute storage reads as zero. With this zero configuration, every lookup misses.
- R2: Configuration writes use `cfg_idx` as follows:
  - 0 to 3 load the channel 0 boundaries of ranks 0 to 3.
  - 4 to 7 load the channel 1 boundaries.
  - 8 and 9 load the channel 0 attributes for the rank pairs 0/1 and 2/3.
  - 10 and 11 load the same attribute pairs for channel 1.
  - In an attribute byte, bits 2:0 belong to the even rank and bits 6:4 to the odd rank. Bits 3 and 7 are ignored.
  - Indices 12 to 15 change nothing.
- R3: The channels are interleaved exactly when all four boundaries and all four 3-bit attributes match between the two channels. Otherwise they are asymmetric.
- R4: The address key K is address bits 32:25. In interleaved mode, rank i hits when 2*B0[i-1] <= K < 2*B0[i], where B0[-1] is 0. On a hit, the channel output equals address bit 7 and the attribute comes from channel 0.
- R5: In asymmetric mode, channel 0 is searched first, with rank i hitting when B0[i-1] <= K < B0[i]. Only if no channel 0 rank hits is channel 1 searched, with rank i hitting when B0[3]+B1[i-1] <= K < B0[3]+B1[i]. A channel 1 hit reports channel 1 and that rank's channel 1 attribute.
- R6: A rank whose boundary equals the boundary below it is never reported as a hit.
- R7: A key at or above the top of memory misses (`out_hit` = 0). The top is 2*B0[3] when interleaved and B0[3]+B1[3] when asymmetric. On a miss, `out_page` and `out_attr_err` are 0.
- R8: On a hit, `out_page` carries the rank's attribute code (0 = empty, 2 = 4 KB, 3 = 8 KB, 4 = 16 KB). `out_attr_err` is 1 exactly when the hit rank's code is reserved, that is 1, 5, 6 or 7.
- R9: A result appears on the output register one clock after its address is accepted. Results leave in order. While `out_valid` is 1 and `out_ready` is 0, all result outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| in_valid | input | 1 | Lookup address valid |
| in_ready | output | 1 | Decoder can accept an address |
| in_addr | input | 33 | Physical address to decode |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_hit | output | 1 | Address falls in a populated rank |
| out_chan | output | 1 | Channel of the hit |
| out_rank | output | 2 | Rank index of the hit |
| out_page | output | 3 | Attribute code of the hit rank |
| out_attr_err | output | 1 | Hit rank carries a reserved attribute code |

## Verification
The hardest situation to reach from the ports is a switch between interleaved and asymmetric mode. The switch is caused by a single field, or is correctly not caused by writes that touch only the ignored attribute bits. To reach it, the stimulus loads two channels that are identical except for one attribute. It then rewrites that byte with the matching code plus set reserved bits, and sweeps the lookups again. Every sweep steps the key through all 256 values, so both edges of each rank range, empty ranks and the top of memory are all hit. The sweeps run under several levels of random `out_ready` back-pressure, which exercises the hold and ordering rules.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
  localparam int ATTR_W  = 3;
  localparam int ODD_LSB = 4;

  typedef logic [ATTR_W-1:0] attr_t;

  // codes outside {empty, 4 KB, 8 KB, 16 KB}
  function automatic logic attr_reserved(attr_t a);
    return (a == 3'b001) || (a >= 3'b101);
  endfunction
endpackage

// File: rtl/rbd_cfg_regs.sv
module rbd_cfg_regs #(
  parameter int RANKS = 4,
  parameter int BW    = 8,
  parameter int IDX_W = 4
) (
  input  logic                                            clk,
  input  logic                                            rst_n,
  input  logic                                            we,
  input  logic [IDX_W-1:0]                                idx,
  input  logic [BW-1:0]                                   wdata,
  output logic [1:0][RANKS-1:0][BW-1:0]                   bnd_q,
  output logic [1:0][RANKS-1:0][rbd_pkg::ATTR_W-1:0]      att_q
);
  localparam int ATT_BASE = 2 * RANKS;
  localparam int PAIRS    = RANKS / 2;
  localparam int LAST_IDX = ATT_BASE + 2 * PAIRS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bnd_q <= '0;
      att_q <= '0;
    end else if (we) begin
      for (int ch = 0; ch < 2; ch++) begin
        for (int r = 0; r < RANKS; r++) begin
          if (int'(idx) == ch * RANKS + r)
            bnd_q[ch][r] <= wdata;
          if (int'(idx) == ATT_BASE + ch * PAIRS + r / 2)
            att_q[ch][r] <= wdata[(r % 2) * rbd_pkg::ODD_LSB +: rbd_pkg::ATTR_W];
        end
      end
    end
  end

  // R2
  unmapped_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(idx) >= LAST_IDX) |=> ($stable(bnd_q) && $stable(att_q)));

  // R2
  bound_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && idx == '0) |=> (bnd_q[0][0] == $past(wdata)));
endmodule

// File: rtl/rbd_sym_detect.sv
module rbd_sym_detect #(
  parameter int RANKS = 4,
  parameter int BW    = 8
) (
  input  logic [1:0][RANKS-1:0][BW-1:0]              bnd_q,
  input  logic [1:0][RANKS-1:0][rbd_pkg::ATTR_W-1:0] att_q,
  output logic                                       intlv
);
  logic [RANKS-1:0] same_bnd;
  logic [RANKS-1:0] same_att;

  for (genvar r = 0; r < RANKS; r++) begin : g_cmp
    assign same_bnd[r] = (bnd_q[0][r] == bnd_q[1][r]);
    assign same_att[r] = (att_q[0][r] == att_q[1][r]);
  end

  assign intlv = (&same_bnd) && (&same_att);
endmodule

// File: rtl/rbd_range_match.sv
module rbd_range_match #(
  parameter int RANKS = 4,
  parameter int KW    = 9,
  parameter int RW    = (RANKS > 1) ? $clog2(RANKS) : 1
) (
  input  logic [KW-1:0]            base,
  input  logic [RANKS-1:0][KW-1:0] bounds,
  input  logic [KW-1:0]            key,
  output logic                     hit,
  output logic [RW-1:0]            idx
);
  logic [RANKS-1:0] in_rng;

  for (genvar r = 0; r < RANKS; r++) begin : g_rng
    if (r == 0) begin : g_first
      assign in_rng[r] = (key >= base) && (key < bounds[r]);
    end else begin : g_rest
      assign in_rng[r] = (key >= bounds[r-1]) && (key < bounds[r]);
    end
  end

  always_comb begin
    hit = |in_rng;
    idx = '0;
    for (int r = RANKS - 1; r >= 0; r--) begin
      if (in_rng[r]) idx = RW'(r);
    end
  end
endmodule

// File: rtl/rank_addr_decoder.sv
module rank_addr_decoder #(
  parameter int ADDR_W    = 33,
  parameter int GRAIN_LSB = 25,
  parameter int BW        = 8,
  parameter int RANKS     = 4,
  parameter int CHSEL_BIT = 7,
  parameter int IDX_W     = $clog2(3 * RANKS),
  parameter int RW        = $clog2(RANKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [IDX_W-1:0]           cfg_idx,
  input  logic [BW-1:0]              cfg_wdata,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [ADDR_W-1:0]          in_addr,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic                       out_hit,
  output logic                       out_chan,
  output logic [RW-1:0]              out_rank,
  output logic [rbd_pkg::ATTR_W-1:0] out_page,
  output logic                       out_attr_err
);
  localparam int KW = BW + 1;

  logic [1:0][RANKS-1:0][BW-1:0]              bnd_q;
  logic [1:0][RANKS-1:0][rbd_pkg::ATTR_W-1:0] att_q;
  logic                                       intlv;

  rbd_cfg_regs #(.RANKS(RANKS), .BW(BW), .IDX_W(IDX_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .idx   (cfg_idx),
    .wdata (cfg_wdata),
    .bnd_q (bnd_q),
    .att_q (att_q)
  );

  rbd_sym_detect #(.RANKS(RANKS), .BW(BW)) u_sym (
    .bnd_q (bnd_q),
    .att_q (att_q),
    .intlv (intlv)
  );

  logic [KW-1:0]            key;
  logic [KW-1:0]            ch0_top;
  logic [RANKS-1:0][KW-1:0] b0k;
  logic [RANKS-1:0][KW-1:0] b1k;
  logic                     unused_addr_bits;

  assign key              = {1'b0, in_addr[GRAIN_LSB +: BW]};
  assign ch0_top          = {1'b0, bnd_q[0][RANKS-1]};
  assign unused_addr_bits = ^{in_addr[GRAIN_LSB-1:CHSEL_BIT+1], in_addr[CHSEL_BIT-1:0]};

  for (genvar r = 0; r < RANKS; r++) begin : g_bounds
    // interleaved: both channels back each rank, so channel 0 spans double
    assign b0k[r] = intlv ? {bnd_q[0][r], 1'b0} : {1'b0, bnd_q[0][r]};
    // asymmetric: channel 1 stacked above channel 0's top
    assign b1k[r] = {1'b0, bnd_q[1][r]} + ch0_top;
  end

  logic          m0_hit, m1_hit;
  logic [RW-1:0] m0_idx, m1_idx;

  rbd_range_match #(.RANKS(RANKS), .KW(KW), .RW(RW)) u_match0 (
    .base   ('0),
    .bounds (b0k),
    .key    (key),
    .hit    (m0_hit),
    .idx    (m0_idx)
  );

  rbd_range_match #(.RANKS(RANKS), .KW(KW), .RW(RW)) u_match1 (
    .base   (ch0_top),
    .bounds (b1k),
    .key    (key),
    .hit    (m1_hit),
    .idx    (m1_idx)
  );

  logic                       hit_d, chan_d, err_d;
  logic [RW-1:0]              rank_d;
  logic [rbd_pkg::ATTR_W-1:0] page_d;

  always_comb begin
    hit_d  = 1'b0;
    chan_d = 1'b0;
    rank_d = '0;
    page_d = '0;
    if (m0_hit) begin
      hit_d  = 1'b1;
      rank_d = m0_idx;
      chan_d = intlv ? in_addr[CHSEL_BIT] : 1'b0;
      page_d = att_q[0][m0_idx];
    end else if (!intlv && m1_hit) begin
      hit_d  = 1'b1;
      rank_d = m1_idx;
      chan_d = 1'b1;
      page_d = att_q[1][m1_idx];
    end
    err_d = hit_d && rbd_pkg::attr_reserved(page_d);
  end

  logic in_fire;
  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_hit      <= 1'b0;
      out_chan     <= 1'b0;
      out_rank     <= '0;
      out_page     <= '0;
      out_attr_err <= 1'b0;
    end else if (in_fire) begin
      out_valid    <= 1'b1;
      out_hit      <= hit_d;
      out_chan     <= chan_d;
      out_rank     <= rank_d;
      out_page     <= page_d;
      out_attr_err <= err_d;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable({out_hit, out_chan, out_rank, out_page, out_attr_err})));

  // R9
  one_cycle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> out_valid);

  // R8
  attr_err_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_attr_err) |-> out_hit);

  // R7
  above_top_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && key >= (intlv ? {bnd_q[0][RANKS-1], 1'b0}
                              : ch0_top + {1'b0, bnd_q[1][RANKS-1]})) |=> !out_hit);

  // R4
  intlv_chan_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && intlv) |=> (!out_hit || out_chan == $past(in_addr[CHSEL_BIT])));
endmodule

// File: tb/rank_addr_decoder_bench.sv
module rank_addr_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [32:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_hit, out_chan, out_attr_err;
  logic [1:0]  out_rank;
  logic [2:0]  out_page;

  rank_addr_decoder u_rank_addr_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_hit(out_hit), .out_chan(out_chan),
    .out_rank(out_rank), .out_page(out_page), .out_attr_err(out_attr_err)
  );

  always #10 clk = ~clk;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  string ph = "R1";

  int mb [2][4];
  int ma [2][4];

  typedef struct {
    bit    hit;
    bit    chan;
    int    rank;
    int    page;
    bit    err;
    string tag;
  } exp_t;

  exp_t q[$];

  bit       held = 0;
  bit       fired_prev = 0;
  bit [7:0] saved;

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL R9 watchdog expired: actual %0d cycles expected < 150000", cycles);
      report();
      $finish;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic bit m_intlv();
    for (int r = 0; r < 4; r++)
      if (mb[0][r] != mb[1][r] || ma[0][r] != ma[1][r]) return 0;
    return 1;
  endfunction

  // behavioural reference for R3..R8
  function automatic exp_t predict(logic [32:0] a);
    exp_t e;
    int k, lo, hi, top;
    bit il;
    e.hit = 0; e.chan = 0; e.rank = 0; e.page = 0; e.err = 0;
    il = m_intlv();
    k  = int'(a[32:25]);
    if (il) begin
      e.tag = "R4";
      top = 2 * mb[0][3];
      lo = 0;
      for (int r = 0; r < 4; r++) begin
        hi = 2 * mb[0][r];
        if (!e.hit && k >= lo && k < hi) begin
          e.hit = 1; e.rank = r; e.chan = a[7]; e.page = ma[0][r];
        end
        lo = hi;
      end
    end else begin
      e.tag = "R5";
      top = mb[0][3] + mb[1][3];
      lo = 0;
      for (int r = 0; r < 4; r++) begin
        hi = mb[0][r];
        if (!e.hit && k >= lo && k < hi) begin
          e.hit = 1; e.rank = r; e.chan = 0; e.page = ma[0][r];
        end
        lo = hi;
      end
      lo = mb[0][3];
      for (int r = 0; r < 4; r++) begin
        hi = mb[0][3] + mb[1][r];
        if (!e.hit && k >= lo && k < hi) begin
          e.hit = 1; e.rank = r; e.chan = 1; e.page = ma[1][r];
        end
        lo = hi;
      end
    end
    if (!e.hit && k >= top) e.tag = "R7";
    e.err = e.hit && (e.page == 1 || e.page >= 5);
    return e;
  endfunction

  task automatic step(bit v, logic [32:0] a, bit rdy);
    exp_t e;
    @(negedge clk);
    in_valid  = v;
    in_addr   = a;
    out_ready = rdy;
    #1;
    if (held) begin
      chk(out_valid === 1'b1, {ph, " R9"}, "valid dropped during stall", int'(out_valid), 1);
      chk({out_hit, out_chan, out_rank, out_page, out_attr_err} === saved,
          {ph, " R9"}, "result changed during stall",
          int'({out_hit, out_chan, out_rank, out_page, out_attr_err}), int'(saved));
    end
    if (fired_prev)
      chk(out_valid === 1'b1, {ph, " R9"}, "result not valid one cycle after accept", int'(out_valid), 1);
    if (out_valid === 1'b1 && out_ready) begin
      if (q.size() == 0) begin
        chk(0, {ph, " R9"}, "unexpected result", 1, 0);
      end else begin
        e = q.pop_front();
        chk(out_hit === e.hit, {ph, " ", e.tag}, "hit", int'(out_hit), int'(e.hit));
        if (e.hit) begin
          chk(out_rank === 2'(e.rank), {ph, " ", e.tag}, "rank", int'(out_rank), e.rank);
          chk(out_chan === e.chan, {ph, " ", e.tag}, "channel", int'(out_chan), int'(e.chan));
        end
        chk(out_page === 3'(e.page), {ph, " R8"}, "page code", int'(out_page), e.page);
        chk(out_attr_err === e.err, {ph, " R8"}, "attribute error", int'(out_attr_err), int'(e.err));
      end
    end
    held  = (out_valid === 1'b1) && !out_ready;
    saved = {out_hit, out_chan, out_rank, out_page, out_attr_err};
    fired_prev = v && (in_ready === 1'b1);
    if (fired_prev) q.push_back(predict(a));
  endtask

  task automatic drain();
    repeat (4) step(0, '0, 1);
    chk(q.size() == 0, {ph, " R9"}, "results left outstanding", q.size(), 0);
  endtask

  // R2 index map mirrored in the model
  task automatic wr(int idx, int d);
    @(negedge clk);
    in_valid  = 0;
    cfg_we    = 1;
    cfg_idx   = 4'(idx);
    cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_we = 0;
    if (idx < 4)       mb[0][idx]     = d & 255;
    else if (idx < 8)  mb[1][idx - 4] = d & 255;
    else if (idx < 12) begin
      ma[(idx - 8) / 2][((idx - 8) % 2) * 2]     = d & 7;
      ma[(idx - 8) / 2][((idx - 8) % 2) * 2 + 1] = (d >> 4) & 7;
    end
  endtask

  // byte r of b0/b1 is rank r boundary, nibble r of a0/a1 is rank r code
  task automatic cfg_all(logic [31:0] b0, logic [31:0] b1,
                         logic [15:0] a0, logic [15:0] a1, int junk);
    drain();
    for (int r = 0; r < 4; r++) begin
      wr(r,     int'(b0[8*r +: 8]));
      wr(4 + r, int'(b1[8*r +: 8]));
    end
    for (int p = 0; p < 2; p++) begin
      wr(8 + p,  int'(a0[8*p +: 4]) | (int'(a0[8*p+4 +: 4]) << 4) | junk);
      wr(10 + p, int'(a1[8*p +: 4]) | (int'(a1[8*p+4 +: 4]) << 4) | junk);
    end
  endtask

  task automatic sweep(int rdy_pct);
    for (int k = 0; k < 256; k++)
      step(1, {k[7:0], 25'($urandom)}, ($urandom % 100) < rdy_pct);
    drain();
  endtask

  initial begin
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < 4; r++) begin
        mb[c][r] = 0;
        ma[c][r] = 0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(out_valid === 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready === 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    ph = "R1";
    sweep(75);

    // R3 R4 identical channels, with an empty rank 2 (R6)
    ph = "R3 R6";
    cfg_all(32'h6428_280A, 32'h6428_280A, 16'h4332, 16'h4332, 0);
    sweep(80);

    // R5 R6 asymmetric, ranks 0 and 1 of channel 0 empty
    ph = "R5 R6";
    cfg_all(32'h3C32_0000, 32'h461E_1E05, 16'h4302, 16'h3244, 0);
    sweep(70);

    // R3 R8 one attribute differs, reserved codes present
    ph = "R3 R8";
    cfg_all(32'h3C14_1408, 32'h3C14_1408, 16'h7312, 16'h4312, 0);
    sweep(90);

    // R2 R3 matching code written with bits 3 and 7 set: now interleaved
    ph = "R2 R3";
    wr(11, 8'hFB);
    sweep(60);

    // R2 unmapped indices must not disturb anything
    ph = "R2";
    for (int i = 12; i < 16; i++) wr(i, 8'hFF);
    sweep(85);

    // R7 top of memory beyond key range and exact-top cases
    ph = "R7";
    cfg_all(32'hFFC0_8040, 32'h0403_0201, 16'h4324, 16'h2342, 0);
    sweep(75);
    cfg_all(32'hC864_3210, 32'hC864_3210, 16'h2222, 16'h2222, 8'h88);
    sweep(75);
    cfg_all(32'h0000_0000, 32'h9060_3010, 16'h0000, 16'h4321, 0);
    sweep(75);

    // R9 heavy and absent back-pressure
    ph = "R9";
    cfg_all(32'h6428_280A, 32'h2010_0804, 16'h5432, 16'h2346, 0);
    sweep(20);
    sweep(100);

    report();
    $finish;
  end
endmodule